// File: doc/BRIEF.md
# Look-Ahead Signature Match and Timeout Unit

This block sits at a destination network interface. Short signatures announcing data packets arrive over a separate, reliable side network, often before the packets they describe. The block keeps them in a small associative pool. Each stored entry carries its own age counter. When a data packet has been fully received and its signature recomputed locally, that value is compared against every stored entry at once. A hit retires one entry and reports the packet as correctly delivered.

Some signatures never find their packets, or some packets never find their signatures. Both point to a fault in the primary network. An entry that grows too old raises a recovery request. So does a signature that cannot be stored because the pool is full. A recomputed signature that finds no entry is parked in a one-deep pending register. A late-arriving announcement can still resolve it there. If none arrives before the wait runs out, a mismatch is flagged.

Error causes are sticky and stay up until software or the recovery controller acknowledges them.

Top module: `sig_match_unit`

## Requirements
- R1: While reset is held and on the first sample after its release, `match_o`, `late_match_o`, `recov_req_o` and all three cause outputs are 0.
- R2: A packet signature equal to a stored entry raises `match_o` for exactly one cycle, on the cycle after the packet is presented, and that entry is freed.
- R3: When several stored entries are equal to the packet signature, only one of them (the lowest slot index) is freed, so each further packet with that value matches once more.
- R4: An announcement and a packet presented in the same cycle are handled as follows. The packet is compared against the pool contents as they were before the insert. If it misses the pool but equals the incoming announcement, it matches (`match_o`=1) and that announcement is not stored.
- R5: The pool accepts DEPTH (12) signatures. An announcement that arrives while all slots are occupied is dropped and sets `cause_full_o` on the next cycle. The insert always takes the lowest free slot.
- R6: A stored entry that sees no match sets `cause_timeout_o` exactly TIMEOUT (4000) clock edges after the edge that stored it, and not one edge earlier.
- R7: Each cause output, once set, stays set until `ack_i` is sampled high, which clears it on the next cycle. `recov_req_o` is high whenever any cause is set.
- R8: A packet signature that misses is held as pending. An announcement equal to the pending value that arrives within the wait raises `late_match_o` on the next cycle, sets no cause, and is not stored.
- R9: A pending signature still unresolved PEND_WAIT (16) edges after it was loaded sets `cause_mismatch_o`, and not one edge earlier.
- R10: A packet that misses while an unresolved pending signature is held is dropped and sets `cause_mismatch_o` on the next cycle.
- R11: An announcement dropped on a full pool leaves no trace: a later packet with that value does not match.
- R12: An entry that has timed out is removed: a later packet with its value does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| la_valid_i | input | 1 | Announcement signature valid this cycle |
| la_sig_i | input | 16 | Announcement signature value |
| pk_valid_i | input | 1 | Recomputed packet signature valid this cycle |
| pk_sig_i | input | 16 | Recomputed packet signature value |
| ack_i | input | 1 | Clears all sticky causes |
| match_o | output | 1 | Packet matched (pool or same-cycle announcement) |
| late_match_o | output | 1 | Pending packet resolved by a late announcement |
| recov_req_o | output | 1 | Recovery request, OR of the causes |
| cause_timeout_o | output | 1 | Sticky: a stored entry aged out |
| cause_full_o | output | 1 | Sticky: announcement arrived with no free slot |
| cause_mismatch_o | output | 1 | Sticky: packet signature never matched or was dropped |

## Verification
Every output is registered, so a match, a late match, an overflow or a dropped packet shows up on the first edge after the stimulus. The two aging results fall due at fixed distances. A timeout comes TIMEOUT edges after the storing edge, and a pending mismatch comes PEND_WAIT edges after the loading edge. The bench drives inputs on the falling edge and samples on the next falling edge, one register stage later. For both deadlines it checks the cause output one edge before the deadline and again at it. Each scenario starts from a fresh reset, so entries left by earlier scenarios cannot age into it.

// File: rtl/sigpool_pkg.sv
package sigpool_pkg;
  typedef struct packed {
    logic timeout;
    logic full;
    logic mismatch;
  } cause_t;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int unsigned N = 12
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;
endmodule

// File: rtl/sig_slot.sv
module sig_slot #(
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned TIMEOUT = 4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] key_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic             expire_o
);
  localparam int unsigned AGE_W = $clog2(TIMEOUT);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT - 1);

  logic             v_q;
  logic [SIG_W-1:0] sig_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      sig_q <= '0;
      age_q <= '0;
    end else if (set_i) begin
      v_q   <= 1'b1;
      sig_q <= sig_i;
      age_q <= '0;
    end else if (clr_i) begin
      v_q   <= 1'b0;
      age_q <= '0;
    end else if (v_q) begin
      age_q <= age_q + AGE_W'(1);
    end
  end

  assign valid_o  = v_q;
  assign hit_o    = v_q && (sig_q == key_i);
  assign expire_o = v_q && (age_q == AGE_LAST);
endmodule

// File: rtl/pend_hold.sv
module pend_hold #(
  parameter int unsigned SIG_W = 16,
  parameter int unsigned WAIT  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             res_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic             valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             expire_o
);
  localparam int unsigned WAIT_W = $clog2(WAIT);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT - 1);

  logic              v_q;
  logic [SIG_W-1:0]  sig_q;
  logic [WAIT_W-1:0] age_q;

  assign expire_o = v_q && !res_i && (age_q == WAIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      sig_q <= '0;
      age_q <= '0;
    end else if (load_i) begin
      v_q   <= 1'b1;
      sig_q <= sig_i;
      age_q <= '0;
    end else if (res_i || expire_o) begin
      v_q   <= 1'b0;
      age_q <= '0;
    end else if (v_q) begin
      age_q <= age_q + WAIT_W'(1);
    end
  end

  assign valid_o = v_q;
  assign sig_o   = sig_q;
endmodule

// File: rtl/sig_match_unit.sv
module sig_match_unit
  import sigpool_pkg::*;
#(
  parameter int unsigned SIG_W     = 16,
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned TIMEOUT   = 4000,
  parameter int unsigned PEND_WAIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             la_valid_i,
  input  logic [SIG_W-1:0] la_sig_i,
  input  logic             pk_valid_i,
  input  logic [SIG_W-1:0] pk_sig_i,
  input  logic             ack_i,
  output logic             match_o,
  output logic             late_match_o,
  output logic             recov_req_o,
  output logic             cause_timeout_o,
  output logic             cause_full_o,
  output logic             cause_mismatch_o
);
  logic [DEPTH-1:0] valid_vec, hit_vec, exp_vec;
  logic [DEPTH-1:0] hit_gnt, ins_gnt, set_vec, clr_vec;
  logic             hit_any, free_any;
  logic             pend_v, pend_exp, pend_res, pend_load, pend_drop;
  logic [SIG_W-1:0] pend_sig;
  logic             bypass, la_store, pk_miss;
  cause_t           ev, cause_q;
  logic             match_q, late_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    sig_slot #(.SIG_W(SIG_W), .TIMEOUT(TIMEOUT)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_vec[i]),
      .clr_i    (clr_vec[i]),
      .sig_i    (la_sig_i),
      .key_i    (pk_sig_i),
      .valid_o  (valid_vec[i]),
      .hit_o    (hit_vec[i]),
      .expire_o (exp_vec[i])
    );
  end

  // one freed entry per packet, lowest index
  lowest_pick #(.N(DEPTH)) u_hit_pick (
    .req_i (hit_vec & {DEPTH{pk_valid_i}}),
    .gnt_o (hit_gnt),
    .any_o (hit_any)
  );

  // insert target from pre-cycle occupancy
  lowest_pick #(.N(DEPTH)) u_free_pick (
    .req_i (~valid_vec),
    .gnt_o (ins_gnt),
    .any_o (free_any)
  );

  pend_hold #(.SIG_W(SIG_W), .WAIT(PEND_WAIT)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pend_load),
    .res_i    (pend_res),
    .sig_i    (pk_sig_i),
    .valid_o  (pend_v),
    .sig_o    (pend_sig),
    .expire_o (pend_exp)
  );

  always_comb begin
    pend_res  = la_valid_i && pend_v && (la_sig_i == pend_sig);
    bypass    = pk_valid_i && !hit_any && la_valid_i && !pend_res &&
                (la_sig_i == pk_sig_i);
    la_store  = la_valid_i && !pend_res && !bypass;
    set_vec   = ins_gnt & {DEPTH{la_store}};
    clr_vec   = hit_gnt | exp_vec;
    pk_miss   = pk_valid_i && !hit_any && !bypass;
    pend_load = pk_miss && (!pend_v || pend_res || pend_exp);
    pend_drop = pk_miss && !pend_load;
    ev.timeout  = |(exp_vec & ~hit_gnt);
    ev.full     = la_store && !free_any;
    ev.mismatch = pend_exp || pend_drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      match_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      cause_q <= ev | (ack_i ? cause_t'('0) : cause_q);
      match_q <= pk_valid_i && (hit_any || bypass);
      late_q  <= pend_res;
    end
  end

  assign match_o          = match_q;
  assign late_match_o     = late_q;
  assign cause_timeout_o  = cause_q.timeout;
  assign cause_full_o     = cause_q.full;
  assign cause_mismatch_o = cause_q.mismatch;
  assign recov_req_o      = |cause_q;
endmodule

// File: rtl/sig_match_chk.sv
module sig_match_chk #(
  parameter int unsigned DEPTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             la_valid_i,
  input logic             pk_valid_i,
  input logic             ack_i,
  input logic             match_o,
  input logic             late_match_o,
  input logic             recov_req_o,
  input logic             cause_full_o,
  input logic [DEPTH-1:0] hit_gnt,
  input logic [DEPTH-1:0] ins_gnt,
  input logic [DEPTH-1:0] set_vec,
  input logic [DEPTH-1:0] valid_vec
);
  // R2
  match_needs_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(pk_valid_i));
  // R8
  late_needs_la_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_match_o |-> $past(la_valid_i));
  // R7
  recov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_req_o && !ack_i) |=> recov_req_o);
  // R3
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_gnt));
  // R5
  ins_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ins_gnt));
  // R5
  ins_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec & valid_vec) == '0);
  // R5
  full_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_full_o) |-> $past(la_valid_i));
endmodule

bind sig_match_unit sig_match_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .la_valid_i   (la_valid_i),
  .pk_valid_i   (pk_valid_i),
  .ack_i        (ack_i),
  .match_o      (match_o),
  .late_match_o (late_match_o),
  .recov_req_o  (recov_req_o),
  .cause_full_o (cause_full_o),
  .hit_gnt      (hit_gnt),
  .ins_gnt      (ins_gnt),
  .set_vec      (set_vec),
  .valid_vec    (valid_vec)
);

// File: tb/tb_sig_match_unit.sv
`timescale 1ns/1ps
module tb_sig_match_unit;
  localparam int unsigned TMO  = 4000;
  localparam int unsigned PW   = 16;
  localparam int unsigned DEP  = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        la_valid_i = 1'b0, pk_valid_i = 1'b0, ack_i = 1'b0;
  logic [15:0] la_sig_i = '0, pk_sig_i = '0;
  logic        match_o, late_match_o, recov_req_o;
  logic        cause_timeout_o, cause_full_o, cause_mismatch_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sig_match_unit dut (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .la_valid_i       (la_valid_i),
    .la_sig_i         (la_sig_i),
    .pk_valid_i       (pk_valid_i),
    .pk_sig_i         (pk_sig_i),
    .ack_i            (ack_i),
    .match_o          (match_o),
    .late_match_o     (late_match_o),
    .recov_req_o      (recov_req_o),
    .cause_timeout_o  (cause_timeout_o),
    .cause_full_o     (cause_full_o),
    .cause_mismatch_o (cause_mismatch_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic cyc(input logic lv, input logic [15:0] ls,
                     input logic pv, input logic [15:0] ps, input logic ak);
    la_valid_i = lv; la_sig_i = ls; pk_valid_i = pv; pk_sig_i = ps; ack_i = ak;
    @(negedge clk);
    la_valid_i = 1'b0; pk_valid_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 recov in reset", recov_req_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 match", match_o, 1'b0);
    check("R1 late", late_match_o, 1'b0);
    check("R1 recov", recov_req_o, 1'b0);
    check("R1 causes", cause_timeout_o | cause_full_o | cause_mismatch_o, 1'b0);
  endtask

  task automatic t_dup();
    do_reset();
    cyc(1, 16'hA0A0, 0, 0, 0);
    cyc(1, 16'hA0A0, 0, 0, 0);
    cyc(0, 0, 1, 16'hA0A0, 0);
    check("R2 first match", match_o, 1'b1);
    idle(1);
    check("R2 match one cycle", match_o, 1'b0);
    cyc(0, 0, 1, 16'hA0A0, 0);
    check("R3 second copy matches", match_o, 1'b1);
    cyc(0, 0, 1, 16'hA0A0, 0);
    check("R3 both copies freed", match_o, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cyc(1, 16'h0B0B, 1, 16'h0B0B, 0);
    check("R4 bypass match", match_o, 1'b1);
    cyc(0, 0, 1, 16'h0B0B, 0);
    check("R4 bypassed not stored", match_o, 1'b0);
    do_reset();
    cyc(1, 16'h0C0C, 0, 0, 0);
    cyc(1, 16'h0C0C, 1, 16'h0C0C, 0);
    check("R4 pool hit pre-insert", match_o, 1'b1);
    cyc(0, 0, 1, 16'h0C0C, 0);
    check("R4 new insert kept", match_o, 1'b1);
    check("R4 no error", recov_req_o, 1'b0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEP; i++) cyc(1, 16'h1000 + 16'(i), 0, 0, 0);
    check("R5 twelve accepted", cause_full_o, 1'b0);
    cyc(1, 16'h2222, 0, 0, 0);
    check("R5 overflow flag", cause_full_o, 1'b1);
    check("R7 recov from full", recov_req_o, 1'b1);
    idle(3);
    check("R7 full sticky", cause_full_o, 1'b1);
    cyc(0, 0, 0, 0, 1);
    check("R7 ack clears", recov_req_o, 1'b0);
    cyc(0, 0, 1, 16'h2222, 0);
    check("R11 dropped sig no match", match_o, 1'b0);
    cyc(0, 0, 1, 16'h1000, 0);
    check("R2 slot0 match", match_o, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset();
    cyc(1, 16'h7777, 0, 0, 0);
    idle(TMO - 1);
    check("R6 not early", cause_timeout_o, 1'b0);
    idle(1);
    check("R6 timeout at deadline", cause_timeout_o, 1'b1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 16'h7777, 0);
    check("R12 aged entry gone", match_o, 1'b0);
  endtask

  task automatic t_pending();
    do_reset();
    cyc(0, 0, 1, 16'h0D0D, 0);
    check("R8 miss no match", match_o, 1'b0);
    idle(3);
    cyc(1, 16'h0D0D, 0, 0, 0);
    check("R8 late match", late_match_o, 1'b1);
    check("R8 no cause", recov_req_o, 1'b0);
    cyc(0, 0, 1, 16'h0D0D, 0);
    check("R8 late sig not stored", match_o, 1'b0);
    do_reset();
    cyc(0, 0, 1, 16'h0E0E, 0);
    idle(PW - 1);
    check("R9 not early", cause_mismatch_o, 1'b0);
    idle(1);
    check("R9 mismatch at deadline", cause_mismatch_o, 1'b1);
    do_reset();
    cyc(0, 0, 1, 16'h0F0F, 0);
    check("R10 first miss held", cause_mismatch_o, 1'b0);
    cyc(0, 0, 1, 16'h1111, 0);
    check("R10 second miss dropped", cause_mismatch_o, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dup();
    t_same_cycle();
    t_full();
    t_pending();
    t_timeout();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule